// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits between the write latches and the page controller of a byte-wide nonvolatile memory model. It watches every latched write (address and data byte) and a pulse that says the byte-load window has closed. From those it detects two keyed command sequences. The short one switches write protection on and also opens a window for data. The long one switches protection off. For each write it says at once whether the page controller may commit that byte to the array.

A protection flag holds the mode. A power-cycle reset (`rst_n`) leaves this flag unchanged and only clears the sequence matcher. The flag goes back to its unprotected default only through a separate manufacturing initialise (`init_n`).

While protection is on, a data write is accepted only inside a window that a fresh three-write key opens. That window closes when the byte-load timer expires. A write that breaks a sequence sends the matcher back to idle. If protection is off, that breaking write still goes through as ordinary data. Key writes that match a step of a sequence never reach the array.

Top module: `swp_sequencer`

## Requirements
- R1: After `init_n` goes low, `prot_on` is 0. While unprotected and the matcher is idle, any write that is not data 0xAA at address 0x5555 is committed (`wr_commit`=1 in the cycle `wr_valid` is high).
- R2: The writes 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555, in consecutive write order, switch protection on. `prot_on` reads 1 from the clock edge that ends the third write onward, whether or not data follows.
- R3: A pulse on `rst_n` alone leaves `prot_on` unchanged. Only `init_n` clears it.
- R4: While `prot_on` is 1 and no key window is open, an ordinary data write gets `wr_commit`=0.
- R5: While protected, data writes that follow the three-write key get `wr_commit`=1 until `load_timeout` pulses. After that pulse they get 0 again.
- R6: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 clear `prot_on` from the edge that ends the sixth write. Writes after that are committed.
- R7: A write that matches the next expected step of a sequence is never committed.
- R8: A write that does not match the next expected step returns the matcher to idle. It is committed if and only if protection is off, and the next write is judged from idle.
- R9: A `load_timeout` pulse discards a partly matched sequence.
- R10: When `load_timeout` and `wr_valid` are high in the same cycle, the write is judged as if the matcher were idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-cycle reset, active low; clears the matcher only |
| init_n | input | 1 | Manufacturing initialise, active low; clears the matcher and the protection flag |
| wr_valid | input | 1 | One latched write is presented this cycle |
| wr_addr | input | 15 | Latched write address |
| wr_data | input | 8 | Latched write data |
| load_timeout | input | 1 | Byte-load window expired (one-cycle pulse) |
| wr_commit | output | 1 | The presented write may be committed to the array |
| prot_on | output | 1 | Write protection enabled |

## Verification
A matcher stuck in the wrong step shows up on `wr_commit` in the same cycle as the next write. A swallowed key write reads 0, and a mismatch after a missed step shows as a data write that is either committed or dropped against the expectation. A wrong flag shows on `prot_on` one edge after the write that should have set or cleared it, and it also shows in whether the data writes that follow are gated. The scoreboard predicts every write's commit bit from the sequence rules, so a stale window or a lost timeout fails on the first write after it.

// File: rtl/swp_sequencer.sv
module swp_sequencer #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter logic [AW-1:0] KEY_ADDR_A = 15'h5555,
  parameter logic [AW-1:0] KEY_ADDR_B = 15'h2AAA,
  parameter logic [DW-1:0] K_LEAD  = 8'hAA,
  parameter logic [DW-1:0] K_SECND = 8'h55,
  parameter logic [DW-1:0] K_ARM   = 8'hA0,
  parameter logic [DW-1:0] K_CLEAR = 8'h80,
  parameter logic [DW-1:0] K_DROP  = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          load_timeout,
  output logic          wr_commit,
  output logic          prot_on
);

  typedef enum logic [2:0] {
    M_IDLE, M_K1, M_K2, M_OPEN, M_C3, M_C4, M_C5
  } mstate_t;

  mstate_t st, cur, nxt;
  logic    prot_q, prot_d, cmd;
  logic    any_rst_n;

  assign any_rst_n = rst_n & init_n;
  assign cur = load_timeout ? M_IDLE : st;

  wire at_a     = (wr_addr == KEY_ADDR_A);
  wire at_b     = (wr_addr == KEY_ADDR_B);
  wire hit_lead = at_a && (wr_data == K_LEAD);
  wire hit_sec  = at_b && (wr_data == K_SECND);
  wire hit_arm  = at_a && (wr_data == K_ARM);
  wire hit_clr  = at_a && (wr_data == K_CLEAR);
  wire hit_drop = at_a && (wr_data == K_DROP);

  always_comb begin
    nxt    = cur;
    cmd    = 1'b0;
    prot_d = prot_q;
    if (wr_valid) begin
      unique case (cur)
        M_IDLE: if (hit_lead) begin nxt = M_K1; cmd = 1'b1; end
        M_K1: begin
          nxt = hit_sec ? M_K2 : M_IDLE;
          cmd = hit_sec;
        end
        M_K2: begin
          if (hit_arm) begin
            nxt = M_OPEN; cmd = 1'b1; prot_d = 1'b1;
          end else if (hit_clr) begin
            nxt = M_C3; cmd = 1'b1;
          end else nxt = M_IDLE;
        end
        M_C3: begin
          nxt = hit_lead ? M_C4 : M_IDLE;
          cmd = hit_lead;
        end
        M_C4: begin
          nxt = hit_sec ? M_C5 : M_IDLE;
          cmd = hit_sec;
        end
        M_C5: begin
          nxt = M_IDLE;
          if (hit_drop) begin cmd = 1'b1; prot_d = 1'b0; end
        end
        M_OPEN: nxt = M_OPEN;
        default: nxt = M_IDLE;
      endcase
    end
  end

  assign wr_commit = wr_valid && !cmd && (!prot_q || cur == M_OPEN);
  assign prot_on   = prot_q;

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) st <= M_IDLE;
    else            st <= nxt;
  end

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n)    prot_q <= 1'b0;
    else if (rst_n) prot_q <= prot_d;
  end

  p_commit_needs_write_r1: assert property (@(posedge clk) disable iff (!any_rst_n)
    wr_commit |-> wr_valid);

  p_arm_only_by_key_r2: assert property (@(posedge clk) disable iff (!any_rst_n)
    $rose(prot_on) |-> $past(wr_valid && wr_addr == KEY_ADDR_A && wr_data == K_ARM));

  p_clear_only_by_key_r6: assert property (@(posedge clk) disable iff (!any_rst_n)
    $fell(prot_on) |-> $past(wr_valid && wr_addr == KEY_ADDR_A && wr_data == K_DROP));

  p_locked_drop_r4: assert property (@(posedge clk) disable iff (!any_rst_n)
    (prot_on && wr_valid && load_timeout && !hit_lead) |-> !wr_commit);

  p_lead_key_swallowed_r7: assert property (@(posedge clk) disable iff (!any_rst_n)
    (wr_valid && load_timeout && hit_lead) |-> !wr_commit);

endmodule

// File: tb/swp_sequencer_test.sv
module swp_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, init_n = 1'b0;
  logic        wr_valid = 1'b0, load_timeout = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_commit, prot_on;

  int total = 0, bad = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  swp_sequencer uut (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .load_timeout(load_timeout),
    .wr_commit(wr_commit), .prot_on(prot_on)
  );

  always @(negedge clk) begin
    #2;
    if (wr_valid) begin
      bit e; string t;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected write commit=%0b expected none", wr_commit);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (wr_commit !== e) begin
          bad++;
          $display("FAIL %s commit actual=%0b expected=%0b", t, wr_commit, e);
        end
      end
    end
  end

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit e,
                    input string t, input bit to = 1'b0);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_valid = 1'b1; load_timeout = to;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    wr_valid = 1'b0; load_timeout = 1'b0;
  endtask

  task automatic tmo();
    @(negedge clk); load_timeout = 1'b1;
    @(negedge clk); load_timeout = 1'b0;
  endtask

  task automatic chk_prot(input bit e, input string t);
    @(negedge clk); #2;
    total++;
    if (prot_on !== e) begin
      bad++;
      $display("FAIL %s prot_on actual=%0b expected=%0b", t, prot_on, e);
    end
  endtask

  task automatic arm(input string t);
    wr(15'h5555, 8'hAA, 1'b0, t);
    wr(15'h2AAA, 8'h55, 1'b0, t);
    wr(15'h5555, 8'hA0, 1'b0, t);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    init_n = 1'b1; rst_n = 1'b1;
    chk_prot(1'b0, "R1 reset");
    wr(15'h0123, 8'h3C, 1'b1, "R1 plain write");
    wr(15'h5555, 8'h11, 1'b1, "R1 key addr other data");

    // R8: break mid-sequence while unprotected
    wr(15'h5555, 8'hAA, 1'b0, "R7 lead key");
    wr(15'h0100, 8'h12, 1'b1, "R8 breaking write passes");
    wr(15'h2AAA, 8'h55, 1'b1, "R8 matcher back at idle");

    // R9: timeout discards a partial match
    wr(15'h5555, 8'hAA, 1'b0, "R9 lead key");
    tmo();
    wr(15'h2AAA, 8'h55, 1'b1, "R9 second key after timeout");

    // R2: arm
    arm("R2 arm key");
    chk_prot(1'b1, "R2 armed");
    wr(15'h0040, 8'h77, 1'b1, "R5 data in open window");
    wr(15'h0041, 8'h78, 1'b1, "R5 second data in window");
    tmo();
    wr(15'h0042, 8'h79, 1'b0, "R4 data after window closes");
    wr(15'h5555, 8'hAA, 1'b0, "R7 lead key protected");
    wr(15'h0043, 8'h01, 1'b0, "R8 breaking write dropped");
    wr(15'h0044, 8'h02, 1'b0, "R4 locked write");

    // R3: power-cycle reset keeps the flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk_prot(1'b1, "R3 survives rst_n");
    wr(15'h0045, 8'h03, 1'b0, "R3 still locked");

    // R5: unlock then page writes, re-arm while protected
    arm("R5 unlock key");
    wr(15'h0080, 8'hF0, 1'b1, "R5 page byte 0");
    wr(15'h00BF, 8'hF1, 1'b1, "R5 page byte 1");
    tmo();

    // R10: timeout and write in the same cycle
    wr(15'h5555, 8'hAA, 1'b0, "R10 lead key");
    wr(15'h2AAA, 8'h55, 1'b0, "R10 second key");
    wr(15'h5555, 8'hA0, 1'b0, "R10 judged from idle", 1'b1);
    wr(15'h0046, 8'h04, 1'b0, "R10 no window opened");

    // R6: disable sequence
    wr(15'h5555, 8'hAA, 1'b0, "R6 step1");
    wr(15'h2AAA, 8'h55, 1'b0, "R6 step2");
    wr(15'h5555, 8'h80, 1'b0, "R6 step3");
    wr(15'h5555, 8'hAA, 1'b0, "R6 step4");
    wr(15'h2AAA, 8'h55, 1'b0, "R6 step5");
    chk_prot(1'b1, "R6 still on before step6");
    wr(15'h5555, 8'h20, 1'b0, "R6 step6");
    chk_prot(1'b0, "R6 cleared");
    wr(15'h0200, 8'h55, 1'b1, "R6 write after disable");

    // R8: broken disable sequence while unprotected
    wr(15'h5555, 8'hAA, 1'b0, "R7 lead");
    wr(15'h2AAA, 8'h55, 1'b0, "R7 second");
    wr(15'h5555, 8'h80, 1'b0, "R7 third");
    wr(15'h1234, 8'h99, 1'b1, "R8 break disable seq");

    // R1/R3: init clears the flag
    arm("R3 arm before init");
    chk_prot(1'b1, "R3 armed");
    @(negedge clk); init_n = 1'b0;
    @(negedge clk); init_n = 1'b1;
    chk_prot(1'b0, "R3 init clears");
    wr(15'h0300, 8'h5A, 1'b1, "R1 unprotected after init");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      bad++; total++;
      $display("FAIL scoreboard left=%0d expected=0", exp_q.size());
    end
    finish_up();
  end
endmodule